// File: doc/BRIEF.md
# Pipeline Register Interlock Controller

This block controls hazards and stalls for an in-order, single-issue pipeline that has no forwarding. Fetch occupies two stages ahead of decode. After decode, an instruction takes one of two execute paths. Integer and branch work finishes in a one-stage path. Floating-point add/sub and every multiply use a longer multi-stage path. Both paths then feed one shared pipelined data-memory section and a single write-back stage. Each cycle the block looks at the instruction sitting in decode: its class, its two source register numbers and its destination register number. It then decides whether that instruction leaves decode. If it cannot, fetch and decode are frozen and a no-op goes into execute in its place.

Each register has a small countdown that records when its outstanding write will land. The register file is written early in the write-back cycle and read late in the decode cycle. A consumer may therefore leave decode in the same cycle its producer writes back.

A reservation vector tracks the single write-back slot, which is also the shared memory entry. Two instructions with different path lengths can never claim that slot in the same cycle. After a branch leaves decode, fetch is held until the branch condition resolves at the end of execute.

Top module: `ilk_interlock`

## Requirements
- R1: After reset no write is pending. With `id_valid_i` low the outputs are `issue_o`=0, `bubble_o`=1, `fetch_en_o`=1 and `dec_en_o`=1. The first valid instruction leaves decode in the cycle it is presented.
- R2: Class codes 0 (integer/logic) and 1 (branch) take the short path; only class 0 writes `id_rd_i`. A short-path producer that issues in cycle s writes back in cycle s+5. A consumer that reads that register through either source field issues no earlier than cycle s+5, and exactly in s+5 if presented right after the producer.
- R3: Class code 4 (FP add/sub or any multiply) writes `id_rd_i` through the long path. A producer issued in cycle s writes back in cycle s+8. A dependent consumer issues no earlier than s+8.
- R4: Class code 2 (load) writes `id_rd_i` with the short-path timing, so a consumer waits until s+5. Class code 3 (store) writes nothing and reads both source fields.
- R5: Register 0 never causes a stall, whether it appears as a source or as a destination.
- R6: An instruction is held if its write-back would coincide with that of an older instruction. Example: a short-path instruction presented 3 cycles after a long-path one issues is delayed by exactly one cycle.
- R7: A writer whose destination already has a pending write that would land at or after its own write is held until its own write lands strictly later. A writer to a different destination is not held.
- R8: In the cycle after a branch issues, `fetch_en_o` is 0 and no instruction issues. Issue resumes in the following cycle.
- R9: While a valid instruction is held, `fetch_en_o`=0, `dec_en_o`=0 and `bubble_o`=1. Pending-write countdowns keep advancing during the hold.
- R10: A load ignores its second source field. A load whose second source names a pending register issues at once.
- R11: When `id_valid_i` is low, nothing issues and the source and destination fields have no effect: `fetch_en_o` stays 1 while no branch hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode holds a real instruction |
| id_cls_i | input | 3 | Instruction class code |
| id_rs1_i | input | REG_AW | First source register number |
| id_rs2_i | input | REG_AW | Second source register number |
| id_rd_i | input | REG_AW | Destination register number |
| fetch_en_o | output | 1 | Both fetch stages may advance |
| dec_en_o | output | 1 | Decode register may load a new instruction |
| issue_o | output | 1 | Decode instruction moves into execute at this edge |
| bubble_o | output | 1 | A no-op enters execute at this edge |

## Verification
Several behaviours hold on every cycle and are checked by the properties. A hold always blocks issue and freezes decode. An invalid decode slot never issues. The cycle after a branch issue is always empty. A writer is never followed by a dependent instruction in the very next cycle. Other behaviours only the bench's scenarios can show. These are the exact issue cycles: short, long and load producers, the one-cycle write-slot delay, the destination ordering wait, register 0 immunity and the ignored second source of a load. Each of these is reached only through specific instruction sequences whose expected cycle counts come from the path lengths.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [2:0] {
      ILK_ALU  = 3'd0,
      ILK_BR   = 3'd1,
      ILK_LD   = 3'd2,
      ILK_ST   = 3'd3,
      ILK_LONG = 3'd4
   } ilk_cls_e;

   typedef struct packed {
      logic rd_a;
      logic rd_b;
      logic wr;
      logic long_path;
      logic branch;
   } ilk_use_t;

   function automatic ilk_use_t cls_use(input logic [2:0] code);
      ilk_use_t u;
      u = '0;
      case (code)
         ILK_BR: begin
            u.rd_a   = 1'b1;
            u.rd_b   = 1'b1;
            u.branch = 1'b1;
         end
         ILK_LD: begin
            u.rd_a = 1'b1;
            u.wr   = 1'b1;
         end
         ILK_ST: begin
            u.rd_a = 1'b1;
            u.rd_b = 1'b1;
         end
         ILK_LONG: begin
            u.rd_a      = 1'b1;
            u.rd_b      = 1'b1;
            u.wr        = 1'b1;
            u.long_path = 1'b1;
         end
         default: begin
            u.rd_a = 1'b1;
            u.rd_b = 1'b1;
            u.wr   = 1'b1;
         end
      endcase
      return u;
   endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
   parameter int REG_AW = 5,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [REG_AW-1:0] set_idx,
   input  logic [CNT_W-1:0]  set_val,
   input  logic [REG_AW-1:0] qa_idx,
   input  logic [REG_AW-1:0] qb_idx,
   input  logic [REG_AW-1:0] qd_idx,
   output logic [CNT_W-1:0]  qa_cnt,
   output logic [CNT_W-1:0]  qb_cnt,
   output logic [CNT_W-1:0]  qd_cnt
);
   localparam int NREG = 1 << REG_AW;

   logic [CNT_W-1:0] cnt_q [NREG];

   // One countdown per register; entry 0 stays at zero forever.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) cnt_q[i] <= '0;
      end else begin
         for (int i = 1; i < NREG; i++) begin
            if (set_en && (set_idx == REG_AW'(i)))
               cnt_q[i] <= set_val;
            else if (cnt_q[i] != '0)
               cnt_q[i] <= cnt_q[i] - CNT_W'(1);
         end
      end
   end

   assign qa_cnt = cnt_q[qa_idx];
   assign qb_cnt = cnt_q[qb_idx];
   assign qd_cnt = cnt_q[qd_idx];

endmodule

// File: rtl/ilk_wb_slots.sv
module ilk_wb_slots #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_en,
   input  logic [CNT_W-1:0] take_lat,
   input  logic [CNT_W-1:0] query_lat,
   output logic             conflict
);
   localparam int SLOTS = 1 << CNT_W;

   logic [SLOTS-1:0] slot_q;
   logic [SLOTS-1:0] slot_nxt;
   logic [CNT_W-1:0] probe;

   always_comb begin
      slot_nxt = slot_q >> 1;
      if (take_en) slot_nxt[take_lat] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_nxt;
   end

   // A slot index one above the latency lines up with the current cycle's view.
   assign probe    = query_lat + CNT_W'(1);
   assign conflict = slot_q[probe];

endmodule

// File: rtl/ilk_branch_hold.sv
module ilk_branch_hold #(
   parameter int HOLD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   generate
      if (HOLD == 0) begin : g_none
         assign active = 1'b0;
      end else begin : g_cnt
         localparam int HW = $clog2(HOLD + 1);
         logic [HW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (start)          left_q <= HW'(HOLD);
            else if (left_q != '0)   left_q <= left_q - HW'(1);
         end
         assign active = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock #(
   parameter int REG_AW   = 5,
   parameter int SHORT_EX = 1,
   parameter int LONG_EX  = 4,
   parameter int MEM_ST   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_valid_i,
   input  logic [2:0]        id_cls_i,
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic [REG_AW-1:0] id_rd_i,
   output logic              fetch_en_o,
   output logic              dec_en_o,
   output logic              issue_o,
   output logic              bubble_o
);
   localparam int L_SHORT = SHORT_EX + MEM_ST + 1;
   localparam int L_LONG  = LONG_EX + MEM_ST + 1;
   localparam int CNT_W   = $clog2(L_LONG + 2);

   initial begin : p_param_chk
      assert (REG_AW >= 1 && SHORT_EX >= 1 && LONG_EX >= SHORT_EX && MEM_ST >= 1)
         else $error("ilk_interlock: illegal parameter set");
   end

   ilk_pkg::ilk_use_t use_c;
   logic [CNT_W-1:0]  lat_c;
   logic [CNT_W-1:0]  cnt_a, cnt_b, cnt_d;
   logic              raw_a, raw_b, waw, slot_busy, br_hold, hazard;

   assign use_c = ilk_pkg::cls_use(id_cls_i);
   assign lat_c = use_c.long_path ? CNT_W'(L_LONG) : CNT_W'(L_SHORT);

   ilk_scoreboard #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (issue_o && use_c.wr),
      .set_idx (id_rd_i),
      .set_val (lat_c),
      .qa_idx  (id_rs1_i),
      .qb_idx  (id_rs2_i),
      .qd_idx  (id_rd_i),
      .qa_cnt  (cnt_a),
      .qb_cnt  (cnt_b),
      .qd_cnt  (cnt_d)
   );

   ilk_wb_slots #(.CNT_W(CNT_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_en   (issue_o),
      .take_lat  (lat_c),
      .query_lat (lat_c),
      .conflict  (slot_busy)
   );

   ilk_branch_hold #(.HOLD(SHORT_EX)) u_brh (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (issue_o && use_c.branch),
      .active (br_hold)
   );

   // Counter value 1 means the write lands this cycle, ahead of the late-cycle read.
   assign raw_a  = use_c.rd_a && (id_rs1_i != '0) && (cnt_a > CNT_W'(1));
   assign raw_b  = use_c.rd_b && (id_rs2_i != '0) && (cnt_b > CNT_W'(1));
   assign waw    = use_c.wr   && (id_rd_i  != '0) && (cnt_d > lat_c);
   assign hazard = id_valid_i && (raw_a || raw_b || waw || slot_busy);

   assign fetch_en_o = !br_hold && !hazard;
   assign dec_en_o   = !br_hold && !hazard;
   assign issue_o    = id_valid_i && !br_hold && !hazard;
   assign bubble_o   = !issue_o;

endmodule

// File: rtl/ilk_interlock_chk.sv
module ilk_interlock_chk #(
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              id_valid_i,
   input logic [2:0]        id_cls_i,
   input logic [REG_AW-1:0] id_rs1_i,
   input logic [REG_AW-1:0] id_rs2_i,
   input logic [REG_AW-1:0] id_rd_i,
   input logic              fetch_en_o,
   input logic              dec_en_o,
   input logic              issue_o,
   input logic              bubble_o
);
   ilk_pkg::ilk_use_t u;
   assign u = ilk_pkg::cls_use(id_cls_i);

   p_hold_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_en_o |-> (!issue_o && bubble_o && !dec_en_o));

   p_invalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid_i |-> (!issue_o && bubble_o));

   p_branch_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && id_cls_i == ilk_pkg::ILK_BR) |=> (!fetch_en_o && !issue_o));

   p_no_adjacent_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && u.wr && id_rd_i != '0) |=>
         !(issue_o && (id_rs1_i == $past(id_rd_i) ||
                       (u.rd_b && id_rs2_i == $past(id_rd_i)))));

endmodule

bind ilk_interlock ilk_interlock_chk #(.REG_AW(REG_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .id_valid_i (id_valid_i),
   .id_cls_i   (id_cls_i),
   .id_rs1_i   (id_rs1_i),
   .id_rs2_i   (id_rs2_i),
   .id_rd_i    (id_rd_i),
   .fetch_en_o (fetch_en_o),
   .dec_en_o   (dec_en_o),
   .issue_o    (issue_o),
   .bubble_o   (bubble_o)
);

// File: tb/tb_ilk_interlock.sv
module tb_ilk_interlock;
   localparam int CLK_P = 10;
   localparam logic [2:0] C_ALU = 3'd0, C_BR = 3'd1, C_LD = 3'd2, C_ST = 3'd3, C_LONG = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       id_valid_i = 1'b0;
   logic [2:0] id_cls_i = '0;
   logic [4:0] id_rs1_i = '0, id_rs2_i = '0, id_rd_i = '0;
   logic       fetch_en_o, dec_en_o, issue_o, bubble_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int    exp_cyc_q [$];
   string exp_req_q [$];

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ilk_interlock dut (
      .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid_i), .id_cls_i(id_cls_i),
      .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i), .id_rd_i(id_rd_i),
      .fetch_en_o(fetch_en_o), .dec_en_o(dec_en_o), .issue_o(issue_o), .bubble_o(bubble_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Monitor: every issue pops the oldest expected item and compares its cycle.
   always @(negedge clk) begin
      if (rst_n && issue_o) begin
         if (exp_cyc_q.size() == 0) begin
            check(1'b0, "R11 unexpected issue", cyc, -1);
         end else begin
            int    e;
            string r;
            e = exp_cyc_q.pop_front();
            r = exp_req_q.pop_front();
            check(cyc == e, r, cyc, e);
         end
      end
   end

   // Driver: present one instruction, predict its issue cycle, wait for it.
   task automatic send(input logic [2:0] cls, input int rd, input int rs1, input int rs2,
                       input int delay, input string req);
      int waited;
      exp_cyc_q.push_back(cyc + delay);
      exp_req_q.push_back(req);
      id_cls_i = cls; id_rd_i = 5'(rd); id_rs1_i = 5'(rs1); id_rs2_i = 5'(rs2);
      id_valid_i = 1'b1;
      waited = 0;
      forever begin
         @(negedge clk);
         if (issue_o) break;
         // R9: a held instruction freezes fetch and decode and feeds a bubble
         check(!fetch_en_o && !dec_en_o && bubble_o, "R9 hold outputs",
               {fetch_en_o, dec_en_o, bubble_o}, 3'b001);
         waited++;
         if (waited > 40) begin
            check(1'b0, "R9 instruction never issued", waited, delay);
            break;
         end
      end
      @(posedge clk); #1;
      id_valid_i = 1'b0;
   endtask

   task automatic idle(input int n, input bit chk);
      id_valid_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (chk)
            check(!issue_o && bubble_o && fetch_en_o && dec_en_o, "R11 idle outputs",
                  {issue_o, bubble_o, fetch_en_o, dec_en_o}, 4'b0111);
         @(posedge clk); #1;
      end
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(fetch_en_o && bubble_o && !issue_o, "R1 outputs in reset",
            {fetch_en_o, bubble_o, issue_o}, 3'b110);
      rst_n = 1'b1;
      @(posedge clk); #1;
      idle(3, 1'b1);                                   // R1 idle after reset
      send(C_ALU, 1, 2, 3, 0, "R1 first issue");
      idle(10, 1'b1);

      // R2: short producer, dependency on each source field
      send(C_ALU, 1, 2, 3, 0, "R2 producer");
      send(C_ALU, 4, 1, 5, 4, "R2 rs1 consumer");
      idle(8, 1'b1);
      send(C_ALU, 5, 2, 3, 0, "R2 producer");
      send(C_ALU, 6, 7, 5, 4, "R2 rs2 consumer");
      idle(8, 1'b1);

      // R3: long producer
      send(C_LONG, 6, 2, 3, 0, "R3 producer");
      send(C_ALU, 7, 1, 6, 7, "R3 consumer");
      idle(10, 1'b1);

      // R4: load producer, store data reader
      send(C_LD, 8, 2, 0, 0, "R4 load");
      send(C_ST, 0, 9, 8, 4, "R4 store");
      idle(8, 1'b1);

      // R5: register 0 never stalls
      send(C_LONG, 0, 2, 3, 0, "R5 long to r0");
      send(C_ALU, 0, 0, 0, 0, "R5 write r0 again");
      send(C_ALU, 9, 0, 0, 0, "R5 read r0");
      idle(10, 1'b1);

      // R6: write slot collision
      send(C_LONG, 10, 2, 3, 0, "R6 long");
      send(C_ALU, 11, 2, 3, 0, "R6 gap1");
      send(C_ALU, 12, 2, 3, 0, "R6 gap2");
      send(C_ALU, 13, 2, 3, 1, "R6 colliding");
      idle(10, 1'b1);

      // R7: destination ordering
      send(C_LONG, 14, 2, 3, 0, "R7 long");
      send(C_ALU, 14, 2, 3, 3, "R7 same dest");
      idle(10, 1'b1);
      send(C_LONG, 15, 2, 3, 0, "R7 long");
      send(C_ALU, 16, 2, 3, 0, "R7 other dest");
      idle(10, 1'b1);

      // R8: branch hold
      send(C_BR, 0, 2, 3, 0, "R8 branch");
      send(C_ALU, 17, 2, 3, 1, "R8 after branch");
      idle(8, 1'b1);
      send(C_ALU, 18, 2, 3, 0, "R8 producer");
      send(C_BR, 0, 18, 2, 4, "R8 dependent branch");
      @(negedge clk);
      check(!fetch_en_o && !issue_o, "R8 fetch held", {fetch_en_o, issue_o}, 2'b00);
      @(posedge clk); #1;
      idle(6, 1'b1);

      // R10: load ignores its second source
      send(C_LONG, 16, 2, 3, 0, "R10 long");
      send(C_LD, 17, 2, 16, 0, "R10 load");
      send(C_ST, 0, 2, 16, 6, "R10 store waits");
      idle(10, 1'b1);

      // R11: invalid slot naming a pending register has no effect
      send(C_LONG, 19, 2, 3, 0, "R11 long");
      id_cls_i = C_ALU; id_rs1_i = 5'd19; id_rs2_i = 5'd19; id_rd_i = 5'd19;
      idle(6, 1'b1);
      idle(6, 1'b1);

      check(exp_cyc_q.size() == 0, "R9 pending expectations", exp_cyc_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule